// File: doc/BRIEF.md
# Programmable Down-Count Timer with Interrupt and Pin Output

This block is a register-mapped down-counting timer for a peripheral subsystem. A bus host programs a reload value through two byte-wide registers and sets the timer's behaviour through one 8-bit control register. Writing the run bit from 0 to 1 loads the reload value into the counter. The counter then decrements once per tick until it reaches zero.

The tick is either every cycle of the block's own clock or every rising edge seen on an external timer clock pin. That pin is synchronised and edge-detected, and the detected edge acts as a clock enable. At each timeout the block sets an interrupt flag. In auto-reload mode it then reloads and carries on counting. In one-shot mode it clears its own run bit and stops.

The flag reaches the interrupt output when interrupts are enabled, and any read of the control register clears it. A timeout can also be sent out as a one-cycle pulse on general-purpose pin 0, provided that pin is not claimed by another function.

Top module: `dctmr_top`

## Requirements
- R1: After reset the control register reads 0x00, and `irq_o` and `gpio0_o` are 0.
- R2: The control register is at address 0. Its fields are bit 0 interrupt enable, bit 1 run, bit 2 one-shot, bit 3 external tick select and bit 4 pin routing. Bits 7:5 always read 0, whatever was written to them.
- R3: The reload value's low byte is at address 1 and its upper bits are at address 2. A control write that takes the run bit from 0 to 1 loads the reload value. The first timeout then comes exactly R ticks later, and a reload value of 0 gives 2^CNT_W ticks.
- R4: With bit 2 = 0 (auto-reload), timeouts repeat every R ticks for as long as the run bit is 1.
- R5: With bit 2 = 1 (one-shot), exactly one timeout occurs, and after it the run bit reads back as 0.
- R6: While the run bit is 0, no timeout occurs.
- R7: With bit 3 = 1, only synchronised rising edges of `ext_clk_i` are counted as ticks. When that pin is idle, no timeout occurs.
- R8: Each timeout sets the interrupt flag. `irq_o` equals the flag ANDed with bit 0, so a flag that is pending when bit 0 is later set shows on `irq_o` at once.
- R9: A read at address 0 clears the flag. If a timeout falls in the same cycle as the read, the flag stays set.
- R10: `gpio0_o` pulses high for exactly one clock cycle at each timeout, but only when bit 4 = 1 and `gpio0_claimed_i` = 0. Otherwise it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the internal tick source |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (control register at address 0, otherwise 0) |
| ext_clk_i | input | 1 | External timer clock pin, asynchronous |
| gpio0_claimed_i | input | 1 | 1 when general-purpose pin 0 is used by another function |
| irq_o | output | 1 | Timer interrupt |
| gpio0_o | output | 1 | Timeout pulse for general-purpose pin 0 |

## Verification
The bench builds the block with CNT_W = 10 and the default two-stage synchroniser. This brings the wrap-around reload value of 0 (1024 ticks) within a short run, so its boundary can be checked cycle by cycle.

Reload values 1 to 7 are swept in both modes. For each one, the pulse on pin 0 is predicted on every cycle from the tick count. Short bursts of external edges, reads that coincide with a timeout, and the claimed-pin case are each placed on exact cycles.

// File: rtl/dctmr_pkg.sv
package dctmr_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] A_RLD_L = 2'd1;
  localparam logic [ADDR_W-1:0] A_RLD_H = 2'd2;

  // control fields, bit 4 down to bit 0
  typedef struct packed {
    logic route;
    logic ext_sel;
    logic one_shot;
    logic run;
    logic irq_en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam int unsigned RUN_BIT = 1;
endpackage

// File: rtl/dctmr_tick.sv
module dctmr_tick #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk_i,
  input  logic ext_sel_i,
  output logic tick_o
);
  localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;
  logic               ext_edge;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], ext_clk_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  // last synchroniser stage against its delayed copy
  assign ext_edge = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

  generate
    if (SYNC_STAGES < 2) begin : g_bad
      initial $error("SYNC_STAGES must be at least 2");
    end
  endgenerate

  always_comb begin
    tick_o = ext_sel_i ? ext_edge : 1'b1;
  end

  a_r7_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge |=> !ext_edge);
endmodule

// File: rtl/dctmr_core.sv
module dctmr_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             one_shot_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             timeout_o,
  output logic             pulse_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;
  logic             step;
  logic             hit;

  always_comb begin
    step  = run_i & tick_i & ~load_i;
    hit   = step & (cnt_q == ONE);
    cnt_d = cnt_q;
    if (load_i)                  cnt_d = reload_i;
    else if (hit && !one_shot_i) cnt_d = reload_i;
    else if (step)               cnt_d = cnt_q - ONE;
    pulse_d = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign timeout_o = hit;
  assign pulse_o   = pulse_q;

  a_r6_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_i) |=> $stable(cnt_q));
  a_r4_reload_after_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !one_shot_i) |=> (cnt_q == $past(reload_i)));
  a_r10_pulse_follows_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> pulse_o);
endmodule

// File: rtl/dctmr_regs.sv
module dctmr_regs
  import dctmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              timeout_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              start_o,
  output logic              flag_o
);
  localparam int unsigned HI_W = CNT_W - DATA_W;

  ctrl_t             ctrl_q, ctrl_d;
  logic [DATA_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0]   hi_q, hi_d;
  logic              flag_q, flag_d;
  logic              wr_ctrl, rd_ctrl;

  always_comb begin
    wr_ctrl = wr_en & (addr == A_CTRL);
    rd_ctrl = rd_en & (addr == A_CTRL);
    start_o = wr_ctrl & wdata[RUN_BIT] & ~ctrl_q.run;

    ctrl_d = ctrl_q;
    if (wr_ctrl)                          ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
    else if (timeout_i && ctrl_q.one_shot) ctrl_d.run = 1'b0;

    lo_d = lo_q;
    if (wr_en && addr == A_RLD_L) lo_d = wdata;
    hi_d = hi_q;
    if (wr_en && addr == A_RLD_H) hi_d = wdata[HI_W-1:0];

    flag_d = flag_q;
    if (timeout_i)    flag_d = 1'b1;
    else if (rd_ctrl) flag_d = 1'b0;

    rdata = '0;
    if (addr == A_CTRL) rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
      flag_q <= flag_d;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = {hi_q, lo_q};
  assign flag_o   = flag_q;

  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_i |=> flag_o);
  a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !timeout_i) |=> !flag_o);
  a_r5_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_i && ctrl_q.one_shot && !wr_ctrl) |=> !ctrl_o.run);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CTRL) |-> (rdata[DATA_W-1:CTRL_W] == '0));
endmodule

// File: rtl/dctmr_top.sv
module dctmr_top
  import dctmr_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        ext_clk_i,
  input  logic        gpio0_claimed_i,
  output logic        irq_o,
  output logic        gpio0_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload;
  logic             start, flag, tick, timeout, pulse;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  dctmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n_int),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .timeout_i(timeout), .ctrl_o(ctrl), .reload_o(reload),
    .start_o(start), .flag_o(flag)
  );

  dctmr_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n_int),
    .ext_clk_i(ext_clk_i), .ext_sel_i(ctrl.ext_sel), .tick_o(tick)
  );

  dctmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n_int),
    .tick_i(tick), .run_i(ctrl.run), .one_shot_i(ctrl.one_shot),
    .load_i(start), .reload_i(reload),
    .timeout_o(timeout), .pulse_o(pulse)
  );

  assign irq_o   = flag & ctrl.irq_en;
  assign gpio0_o = pulse & ctrl.route & ~gpio0_claimed_i;

  a_r10_gpio_gated: assert property (@(posedge clk) disable iff (!rst_n_int)
    gpio0_o |-> !gpio0_claimed_i);
  a_r6_no_timeout_stopped: assert property (@(posedge clk) disable iff (!rst_n_int)
    !ctrl.run |-> !timeout);
endmodule

// File: tb/dctmr_top_tb.sv
module dctmr_top_tb;
  localparam int W = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       ext_clk = 1'b0, claimed = 1'b0;
  logic       irq, gpio;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dctmr_top #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_clk_i(ext_clk),
    .gpio0_claimed_i(claimed), .irq_o(irq), .gpio0_o(gpio)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = 2'd0; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic stop_clear();
    logic [7:0] v;
    wr(2'd0, 8'h00);
    rd(v);
  endtask

  task automatic set_reload(input int r);
    wr(2'd1, 8'(r & 8'hFF));
    wr(2'd2, 8'((r >> 8) & 3));
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext_clk = 1'b1;
    repeat (3) @(negedge clk);
    ext_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    #1 chk(rdata == 8'h00, "R1 ctrl reset", rdata, 0);
    chk(irq == 1'b0, "R1 irq reset", irq, 0);
    chk(gpio == 1'b0, "R1 gpio reset", gpio, 0);

    // R2 reserved bits read 0
    wr(2'd0, 8'hE0);
    rd(v);
    chk(v == 8'h00, "R2 reserved", v, 0);
    wr(2'd0, 8'hFD);
    rd(v);
    chk(v == 8'h1D, "R2 readback", v, 8'h1D);
    stop_clear();

    // R3 R4 R5 R10 sweep: reload 1..7 in both modes
    for (int m = 0; m < 2; m++) begin
      for (int r = 1; r <= 7; r++) begin
        stop_clear();
        set_reload(r);
        wr(2'd0, 8'(8'h13 | (m << 2)));
        for (int i = 1; i <= 3 * r; i++) begin
          bit exp_g;
          @(negedge clk);
          exp_g = (m == 0) ? (i % r == 0) : (i == r);
          chk(gpio == exp_g, (m == 0) ? "R4 R10 retrigger pulse" : "R5 R10 oneshot pulse",
              gpio, exp_g);
          if (i == r - 1) chk(irq == 1'b0, "R3 irq before timeout", irq, 0);
          if (i == r)     chk(irq == 1'b1, "R3 R8 irq at timeout", irq, 1);
        end
        if (m == 1) begin
          rd(v);
          chk(v == 8'h15, "R5 run cleared", v, 8'h15);
        end
      end
    end

    // R3 reload 0 means 2^W ticks
    stop_clear();
    set_reload(0);
    wr(2'd0, 8'h07);
    repeat ((1 << W) - 1) @(negedge clk);
    chk(irq == 1'b0, "R3 zero reload early", irq, 0);
    @(negedge clk);
    chk(irq == 1'b1, "R3 zero reload wrap", irq, 1);

    // R6 stop suppresses timeouts
    stop_clear();
    set_reload(4);
    wr(2'd0, 8'h13);
    @(negedge clk);
    wr(2'd0, 8'h11);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(gpio == 1'b0 && irq == 1'b0, "R6 stopped", gpio | irq, 0);
    end

    // R7 external tick
    stop_clear();
    set_reload(3);
    wr(2'd0, 8'h0B);
    repeat (20) @(negedge clk);
    chk(irq == 1'b0, "R7 idle ext pin", irq, 0);
    ext_pulse();
    ext_pulse();
    chk(irq == 1'b0, "R7 two edges", irq, 0);
    ext_pulse();
    chk(irq == 1'b1, "R7 three edges", irq, 1);

    // R8 enable later shows pending flag
    stop_clear();
    set_reload(2);
    wr(2'd0, 8'h06);
    repeat (5) @(negedge clk);
    chk(irq == 1'b0, "R8 masked", irq, 0);
    wr(2'd0, 8'h01);
    chk(irq == 1'b1, "R8 pending shown", irq, 1);
    rd(v);
    chk(irq == 1'b0, "R9 read clears", irq, 0);

    // R9 read colliding with timeout keeps flag
    stop_clear();
    set_reload(2);
    wr(2'd0, 8'h03);
    rd(v);
    chk(irq == 1'b1, "R9 collision keeps flag", irq, 1);
    wr(2'd0, 8'h01);
    rd(v);
    chk(v == 8'h01, "R9 ctrl value", v, 1);
    chk(irq == 1'b0, "R9 plain clear", irq, 0);

    // R10 claimed pin blocks pulse
    stop_clear();
    claimed = 1'b1;
    set_reload(1);
    wr(2'd0, 8'h13);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(gpio == 1'b0, "R10 claimed pin", gpio, 0);
    end
    claimed = 1'b0;
    @(negedge clk);
    chk(gpio == 1'b1, "R10 released pin", gpio, 1);
    stop_clear();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule